// File: doc/BRIEF.md
# Bank-Spanning Burst Address Counter

This block generates the access address for one port of a banked memory. On every rising clock edge it selects the address to use for the coming access and holds it in an output register. The choice is one of four: a new address taken from the external bus, the previous address plus one, the previous address unchanged, or a recalled address saved from an earlier external load. The address is a single binary value. Its upper field selects one of the banks and its lower field is the word offset inside that bank. Incrementing therefore runs straight from the last offset of one bank into the first offset of the next bank.

The control strobes are active low and plain: a load strobe, a count-enable strobe and a repeat strobe. They have a fixed priority. Repeat is strongest, then load, then count enable, and with none of them asserted the counter holds. Each accepted external load is also copied into a separate repeat register. The repeat strobe later brings the counter back to that value, which lets a burst be replayed from its start. The repeat register has no reset value. A flag output shows whether it holds a loaded address yet. The block has no chip-enable or byte-enable inputs, so address sequencing does not depend on whether any data access takes place. There is no streaming data path, so no valid/ready handshake is used.

Top module: `burst_addr_gen`

## Requirements
- R1: While the synchronous, active-high reset is high at a clock edge, the next outputs are bank 0, offset 0, and the repeat-valid flag is 0.
- R2: When the repeat strobe is high and the load strobe is low at an edge, the output after that edge equals the external address, and the repeat-valid flag becomes 1.
- R3: When repeat and load are high and the count-enable strobe is low at an edge, the output after that edge is the previous output plus one.
- R4: When repeat, load and count enable are all high at an edge, the output keeps its previous value.
- R5: When the repeat strobe is low at an edge and the repeat-valid flag is 1, the output after that edge equals the address saved by the most recent accepted load.
- R6: Repeat has priority over load and count enable. A load strobe given while repeat is low neither changes the output to the external address nor updates the saved repeat address.
- R7: Advancing from offset FFFh of bank b gives offset 0 of bank b+1.
- R8: Advancing from bank 63, offset FFFh gives bank 0, offset 0.
- R9: When the repeat strobe is low while the repeat-valid flag is 0, the output holds and the flag stays 0.
- R10: Every accepted load overwrites the saved repeat address, so repeat always recalls the latest load.
- R11: The 18-bit external address carries the bank in bits 17:12 and the offset in bits 11:0. The bank and offset outputs report those same fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| ext_addr | input | 18 | External address: bank in 17:12, offset in 11:0 |
| load_n | input | 1 | Load external address, active low |
| adv_n | input | 1 | Advance counter by one, active low |
| rep_n | input | 1 | Recall saved repeat address, active low |
| bank_o | output | 6 | Bank of the current access address |
| offs_o | output | 12 | Offset of the current access address |
| rep_valid_o | output | 1 | Saved repeat address holds a loaded value |

## Verification
On every cycle the assertions check the cycle-to-cycle relations of the address register. A load gives the external address, an advance gives the previous value plus one, a hold or an unarmed repeat gives no change, and an armed repeat gives the saved value. The bench scenarios cover the behaviour that depends on history. These are the reset contents, which of several loads a repeat recalls, a load ignored under repeat leaving the saved value alone, and the crossings at the bank boundary and at the top of the address space. A seeded random stream with skewed strobe densities mixes all of these against a reference model kept in the bench.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;
  typedef enum logic [1:0] {
    OP_HOLD   = 2'd0,
    OP_LOAD   = 2'd1,
    OP_STEP   = 2'd2,
    OP_RECALL = 2'd3
  } addr_op_e;
endpackage

// File: rtl/addr_cmd_decode.sv
module addr_cmd_decode
  import burst_addr_pkg::*;
(
  input  logic     load_n,
  input  logic     adv_n,
  input  logic     rep_n,
  input  logic     rep_valid,
  output addr_op_e op,
  output logic     take_load
);
  // fixed priority: repeat, load, count enable, hold
  always_comb begin
    if (!rep_n)       op = rep_valid ? OP_RECALL : OP_HOLD;
    else if (!load_n) op = OP_LOAD;
    else if (!adv_n)  op = OP_STEP;
    else              op = OP_HOLD;
  end

  assign take_load = rep_n & ~load_n;
endmodule

// File: rtl/addr_repeat_store.sv
module addr_repeat_store #(
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take,
  input  logic [ADDR_W-1:0] ext_addr,
  output logic [ADDR_W-1:0] saved,
  output logic              valid
);
  // contents are deliberately not reset; only the valid flag is
  always_ff @(posedge clk) begin
    if (take) saved <= ext_addr;
  end

  always_ff @(posedge clk) begin
    if (rst)       valid <= 1'b0;
    else if (take) valid <= 1'b1;
  end

  a_r10_saved_tracks_load: assert property (@(posedge clk) disable iff (rst)
    take |=> (saved == $past(ext_addr)) && valid);
endmodule

// File: rtl/addr_next_sel.sv
module addr_next_sel
  import burst_addr_pkg::*;
#(
  parameter int ADDR_W = 18
) (
  input  addr_op_e          op,
  input  logic [ADDR_W-1:0] cur,
  input  logic [ADDR_W-1:0] ext_addr,
  input  logic [ADDR_W-1:0] saved,
  output logic [ADDR_W-1:0] nxt
);
  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  // one flat increment: offset carry ripples into the bank field,
  // and the top address wraps naturally to zero
  always_comb begin
    unique case (op)
      OP_LOAD:   nxt = ext_addr;
      OP_STEP:   nxt = cur + ONE;
      OP_RECALL: nxt = saved;
      default:   nxt = cur;
    endcase
  end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_addr_pkg::*;
#(
  parameter int BANK_W = 6,
  parameter int OFFS_W = 12
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [BANK_W+OFFS_W-1:0] ext_addr,
  input  logic                     load_n,
  input  logic                     adv_n,
  input  logic                     rep_n,
  output logic [BANK_W-1:0]        bank_o,
  output logic [OFFS_W-1:0]        offs_o,
  output logic                     rep_valid_o
);
  localparam int ADDR_W = BANK_W + OFFS_W;

  addr_op_e          op;
  logic              take_load;
  logic              rep_valid;
  logic [ADDR_W-1:0] saved;
  logic [ADDR_W-1:0] nxt;
  logic [ADDR_W-1:0] cur;

  addr_cmd_decode u_dec (
    .load_n   (load_n),
    .adv_n    (adv_n),
    .rep_n    (rep_n),
    .rep_valid(rep_valid),
    .op       (op),
    .take_load(take_load)
  );

  addr_repeat_store #(.ADDR_W(ADDR_W)) u_rep (
    .clk     (clk),
    .rst     (rst),
    .take    (take_load),
    .ext_addr(ext_addr),
    .saved   (saved),
    .valid   (rep_valid)
  );

  addr_next_sel #(.ADDR_W(ADDR_W)) u_sel (
    .op      (op),
    .cur     (cur),
    .ext_addr(ext_addr),
    .saved   (saved),
    .nxt     (nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) cur <= '0;
    else     cur <= nxt;
  end

  assign bank_o      = cur[ADDR_W-1:OFFS_W];
  assign offs_o      = cur[OFFS_W-1:0];
  assign rep_valid_o = rep_valid;

  a_r2_load_takes_ext: assert property (@(posedge clk) disable iff (rst)
    (rep_n && !load_n) |=> cur == $past(ext_addr));

  a_r3_step_plus_one: assert property (@(posedge clk) disable iff (rst)
    (rep_n && load_n && !adv_n) |=> cur == ADDR_W'($past(cur) + 1'b1));

  a_r4_idle_holds: assert property (@(posedge clk) disable iff (rst)
    (rep_n && load_n && adv_n) |=> $stable(cur));

  a_r5_recall_saved: assert property (@(posedge clk) disable iff (rst)
    (!rep_n && rep_valid) |=> cur == $past(saved));

  a_r9_unarmed_repeat: assert property (@(posedge clk) disable iff (rst)
    (!rep_n && !rep_valid) |=> $stable(cur) && !rep_valid);
endmodule

// File: tb/burst_addr_gen_test.sv
module burst_addr_gen_test;
  localparam int BW = 6;
  localparam int OW = 12;
  localparam int AW = BW + OW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] ext_addr = '0;
  logic          load_n = 1'b1, adv_n = 1'b1, rep_n = 1'b1;
  logic [BW-1:0] bank_o;
  logic [OW-1:0] offs_o;
  logic          rep_valid_o;

  int checks = 0;
  int errors = 0;

  logic [AW-1:0] m_cur;
  logic [AW-1:0] m_saved;
  logic          m_valid;

  always #5 clk = ~clk;

  burst_addr_gen uut (
    .clk(clk), .rst(rst), .ext_addr(ext_addr),
    .load_n(load_n), .adv_n(adv_n), .rep_n(rep_n),
    .bank_o(bank_o), .offs_o(offs_o), .rep_valid_o(rep_valid_o)
  );

  function automatic logic [AW-1:0] ref_next(logic [AW-1:0] c, logic [AW-1:0] e,
                                             logic [AW-1:0] s, logic v,
                                             logic ld, logic ad, logic rp);
    if (!rp)      return v ? s : c;
    else if (!ld) return e;
    else if (!ad) return c + 1'b1;
    else          return c;
  endfunction

  task automatic check(string tag, logic [AW-1:0] exp_a, logic exp_v);
    checks++;
    if ({bank_o, offs_o} !== exp_a || rep_valid_o !== exp_v) begin
      errors++;
      $display("FAIL %s: got addr=%05h valid=%0b, expected addr=%05h valid=%0b",
               tag, {bank_o, offs_o}, rep_valid_o, exp_a, exp_v);
    end
  endtask

  // drive at negedge, model updates at posedge, compare at next negedge
  task automatic step(string tag, logic ld, logic ad, logic rp, logic [AW-1:0] e);
    load_n = ld; adv_n = ad; rep_n = rp; ext_addr = e;
    @(posedge clk);
    m_cur = ref_next(m_cur, e, m_saved, m_valid, ld, ad, rp);
    if (rp && !ld) begin m_saved = e; m_valid = 1'b1; end
    @(negedge clk);
    check(tag, m_cur, m_valid);
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    m_cur = '0; m_saved = '0; m_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 reset state", '0, 1'b0);

    step("R9 repeat before any load", 1'b0, 1'b0, 1'b0, 18'h1_2345);
    step("R3 advance from zero", 1'b1, 1'b0, 1'b1, '0);
    step("R2 load external", 1'b0, 1'b1, 1'b1, 18'h0_3FFE);
    step("R3 advance", 1'b1, 1'b0, 1'b1, '0);
    step("R7 cross into next bank", 1'b1, 1'b0, 1'b1, '0);
    check("R7 bank 4 offset 0", 18'h0_4000, 1'b1);
    step("R4 hold", 1'b1, 1'b1, 1'b1, 18'h2_AAAA);
    step("R2 load top address", 1'b0, 1'b0, 1'b1, 18'h3_FFFF);
    step("R8 wrap to zero", 1'b1, 1'b0, 1'b1, '0);
    check("R8 bank 0 offset 0", '0, 1'b1);
    step("R5 recall", 1'b1, 1'b0, 1'b0, '0);
    step("R6 load under repeat ignored", 1'b0, 1'b0, 1'b0, 18'h0_0777);
    step("R6 advance after ignored load", 1'b1, 1'b0, 1'b1, '0);
    step("R6 saved untouched", 1'b1, 1'b1, 1'b0, '0);
    check("R6 recall still top", 18'h3_FFFF, 1'b1);
    step("R10 first load", 1'b0, 1'b1, 1'b1, 18'h0_1111);
    step("R11 second load", 1'b0, 1'b1, 1'b1, 18'h2_A123);
    checks++;
    if (bank_o !== 6'h2A || offs_o !== 12'h123) begin
      errors++;
      $display("FAIL R11 field split: got bank=%0h offs=%0h, expected bank=2a offs=123",
               bank_o, offs_o);
    end
    step("R3 advance", 1'b1, 1'b0, 1'b1, '0);
    step("R10 recall latest load", 1'b1, 1'b1, 1'b0, '0);
    check("R10 latest", 18'h2_A123, 1'b1);

    for (int i = 0; i < 3000; i++) begin
      logic ld, ad, rp;
      logic [AW-1:0] e;
      ld = ($urandom % 6) != 0;
      ad = ($urandom % 3) == 0;
      rp = ($urandom % 10) != 0;
      e  = ($urandom % 4 == 0) ? {6'($urandom), 12'hFFE + 12'($urandom % 2)}
                                : AW'($urandom);
      if (i == 1500) begin
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        m_cur = '0; m_valid = 1'b0;
        check("R1 mid-run reset", '0, 1'b0);
      end
      if (!rp)      step(m_valid ? "R5 random recall" : "R9 random unarmed", ld, ad, rp, e);
      else if (!ld) step("R2 random load", ld, ad, rp, e);
      else if (!ad) step("R3 random advance", ld, ad, rp, e);
      else          step("R4 random hold", ld, ad, rp, e);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule